// File: doc/BRIEF.md
# Debug Register Access Decoder

This block is the register-file front end for a set of eight debug register indices. A 3-bit write index and a 3-bit read index select one of four breakpoint address registers, a status register or a control register. Indices 0 to 3 map directly onto the address slots. Index 6 maps onto status and index 7 onto control. Indices 4 and 5 are legacy aliases of status and control. They are honoured only while the debug-extensions mode input is low. While that mode is high, they are illegal and produce a fault pulse.

Writes to status and control always force a fixed pattern of one bits. A write can change what the breakpoint-matching logic downstream must watch. In that case the block raises a per-slot re-arm pulse one cycle after the write, so that the matcher can reload the affected slots. The matching itself lives elsewhere. The control layout that this block decodes is fixed as follows:
- each slot i has a local enable at bit 2i and a global enable at bit 2i+1;
- each slot i has a 2-bit type field at bits 16+4i and 17+4i;
- the type code 2'b10 marks a slot as an I/O-port slot.

Top module: `dbg_reg_access`

## Requirements
- R1: After reset the four address registers read 0, status reads 0xFFFF0FF0, control reads 0x00000400, acc_fault is low and rearm is 0.
- R2: Indices 0 to 3 select address slots 0 to 3. A write stores wr_data unchanged and is visible on the combinational read port from the cycle after the write strobe.
- R3: Index 6 selects status and index 7 selects control. A status write stores wr_data OR 0xFFFF0FF0, and a control write stores wr_data OR 0x00000400.
- R4: With dbg_ext_en low, index 4 behaves exactly as index 6 and index 5 exactly as index 7, for reads and writes.
- R5: With dbg_ext_en high, a strobed access to index 4 or 5 raises acc_fault in the same cycle as the strobe. The access changes no register and produces no re-arm, and rd_data reads 0 for such an index.
- R6: acc_fault is low whenever no strobe is active or the strobed indices are legal for the current mode.
- R7: A write to address slot i sets rearm bit i in the next cycle if, and only if, the current control word enables slot i (bit 2i or bit 2i+1 set) and the slot's type field (bits 17+4i:16+4i) is not 2'b10. No other rearm bit is set.
- R8: Consider a control write whose forced new value differs from the old value only within bits 7:0. In the next cycle, rearm bit i is set exactly for the slots whose combined enable (bit 2i OR bit 2i+1) changed state.
- R9: A control write whose forced new value differs from the old value anywhere above bit 7 sets all four rearm bits in the next cycle.
- R10: rearm is a one-cycle pulse. It is 0 in any cycle not preceded by an address or control write, and status writes never raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_ext_en | input | 1 | Debug-extensions mode; high makes indices 4 and 5 illegal |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 3 | Write register index |
| wr_data | input | DW (32) | Write data |
| rd_en | input | 1 | Read strobe (used for fault detection and the registered read variant) |
| rd_idx | input | 3 | Read register index |
| rd_data | output | DW (32) | Read data, combinational from rd_idx by default |
| acc_fault | output | 1 | Illegal-index pulse, same cycle as the offending strobe |
| rearm | output | 4 | Per-slot re-arm pulse, one cycle after the causing write |

## Verification
The first sweep writes and reads every index under both mode settings. This separates direct mapping, aliasing and faulting, and it shows whether the fixed ones are forced on the right register. The second sweep covers every value of the control enable byte while the upper bits stay unchanged. This distinguishes the per-slot re-arm of the narrow path from the all-slots re-arm of the wide path. The third sweep walks all 256 combinations of slot type codes together with varied enable patterns, then writes each address slot. This shows whether the I/O-type exclusion and the enable qualification are applied per slot. Further writes flip single control bits above the enable byte. One of them toggles only the forced bit, which must leave rearm at 0.

// File: rtl/dbg_pkg.sv
`timescale 1ns/1ps
package dbg_pkg;

   // Number of breakpoint address slots behind indices 0..3.
   localparam int unsigned NUM_SLOTS = 4;
   localparam int unsigned IDX_W     = 3;
   localparam int unsigned SLOT_W    = 2;

   // Register targeted by a decoded index.
   typedef enum logic [1:0] {
      TGT_ADDR = 2'd0,
      TGT_STAT = 2'd1,
      TGT_CTRL = 2'd2,
      TGT_BAD  = 2'd3
   } dbg_tgt_e;

   typedef struct packed {
      dbg_tgt_e            tgt;
      logic [SLOT_W-1:0]   slot;
   } dbg_sel_t;

endpackage

// File: rtl/dbg_idx_decode.sv
`timescale 1ns/1ps
// Maps a 3-bit register index and the extensions mode onto a target.
module dbg_idx_decode
   import dbg_pkg::*;
(
   input  logic [IDX_W-1:0] idx,
   input  logic             ext_mode,
   output dbg_sel_t         sel
);

   always_comb begin
      sel.slot = idx[SLOT_W-1:0];
      case (idx)
         3'd0, 3'd1, 3'd2, 3'd3: sel.tgt = TGT_ADDR;
         3'd4:                   sel.tgt = ext_mode ? TGT_BAD : TGT_STAT;
         3'd5:                   sel.tgt = ext_mode ? TGT_BAD : TGT_CTRL;
         3'd6:                   sel.tgt = TGT_STAT;
         default:                sel.tgt = TGT_CTRL;
      endcase
   end

endmodule

// File: rtl/dbg_rearm_calc.sv
`timescale 1ns/1ps
// Computes which slots must be reloaded by the matcher after a write.
module dbg_rearm_calc
   import dbg_pkg::*;
#(
   parameter int unsigned    DW        = 32,
   parameter int unsigned    TYPE_LSB  = 16,
   parameter logic [1:0]     IO_CODE   = 2'b10,
   parameter logic [DW-1:0]  CTRL_ONES = 32'h0000_0400
)(
   input  logic                 fire,
   input  dbg_sel_t             sel,
   input  logic [DW-1:0]        ctrl_q,
   input  logic [DW-1:0]        wr_data,
   output logic [NUM_SLOTS-1:0] rearm_nxt
);

   localparam int unsigned   EN_BITS = 2 * NUM_SLOTS;
   localparam int unsigned   TYPE_STRIDE = 4;
   localparam logic [DW-1:0] EN_MASK = {{(DW-EN_BITS){1'b0}}, {EN_BITS{1'b1}}};

   logic [DW-1:0]        ctrl_new;
   logic                 wide_change;
   logic [NUM_SLOTS-1:0] en_old;
   logic [NUM_SLOTS-1:0] en_new;
   logic [NUM_SLOTS-1:0] is_io;

   assign ctrl_new    = wr_data | CTRL_ONES;
   assign wide_change = |((ctrl_q ^ ctrl_new) & ~EN_MASK);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      assign en_old[i] = |ctrl_q[2*i +: 2];
      assign en_new[i] = |ctrl_new[2*i +: 2];
      assign is_io[i]  = (ctrl_q[TYPE_LSB + TYPE_STRIDE*i +: 2] == IO_CODE);
   end

   always_comb begin
      rearm_nxt = '0;
      if (fire) begin
         case (sel.tgt)
            TGT_ADDR: rearm_nxt[sel.slot] = en_old[sel.slot] & ~is_io[sel.slot];
            TGT_CTRL: rearm_nxt = wide_change ? {NUM_SLOTS{1'b1}} : (en_old ^ en_new);
            default:  rearm_nxt = '0;
         endcase
      end
   end

endmodule

// File: rtl/dbg_regfile.sv
`timescale 1ns/1ps
// Storage for the address slots, status and control words.
module dbg_regfile
   import dbg_pkg::*;
#(
   parameter int unsigned    DW        = 32,
   parameter logic [DW-1:0]  STAT_ONES = 32'hFFFF_0FF0,
   parameter logic [DW-1:0]  CTRL_ONES = 32'h0000_0400
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          fire,
   input  dbg_sel_t                      sel,
   input  logic [DW-1:0]                 wr_data,
   output logic [NUM_SLOTS-1:0][DW-1:0]  addr_q,
   output logic [DW-1:0]                 stat_q,
   output logic [DW-1:0]                 ctrl_q
);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_addr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            addr_q[i] <= '0;
         else if (fire && sel.tgt == TGT_ADDR && sel.slot == SLOT_W'(i))
            addr_q[i] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat_q <= STAT_ONES;
      else if (fire && sel.tgt == TGT_STAT)
         stat_q <= wr_data | STAT_ONES;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= CTRL_ONES;
      else if (fire && sel.tgt == TGT_CTRL)
         ctrl_q <= wr_data | CTRL_ONES;
   end

endmodule

// File: rtl/dbg_reg_access.sv
`timescale 1ns/1ps
// Debug register access decoder: index decode, aliasing, fixed ones,
// illegal-access fault and re-arm pulse generation.
module dbg_reg_access
   import dbg_pkg::*;
#(
   parameter int unsigned    DW        = 32,
   parameter logic [DW-1:0]  STAT_ONES = 32'hFFFF_0FF0,
   parameter logic [DW-1:0]  CTRL_ONES = 32'h0000_0400,
   parameter int unsigned    TYPE_LSB  = 16,
   parameter logic [1:0]     IO_CODE   = 2'b10,
   parameter bit             REG_READ  = 1'b0
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 dbg_ext_en,
   input  logic                 wr_en,
   input  logic [2:0]           wr_idx,
   input  logic [DW-1:0]        wr_data,
   input  logic                 rd_en,
   input  logic [2:0]           rd_idx,
   output logic [DW-1:0]        rd_data,
   output logic                 acc_fault,
   output logic [NUM_SLOTS-1:0] rearm
);

   localparam int unsigned   EN_BITS  = 2 * NUM_SLOTS;
   localparam int unsigned   TYPE_TOP = TYPE_LSB + 4 * NUM_SLOTS;
   localparam logic [DW-1:0] EN_MASK  = {{(DW-EN_BITS){1'b0}}, {EN_BITS{1'b1}}};

   // Elaboration-time parameter checks
   if (TYPE_TOP > DW) begin : g_bad_type_lsb
      $error("dbg_reg_access: type fields do not fit in DW");
   end
   if ((CTRL_ONES & EN_MASK) != '0) begin : g_bad_ctrl_ones
      $error("dbg_reg_access: forced control bits overlap enable bits");
   end
   if (TYPE_LSB < EN_BITS) begin : g_bad_overlap
      $error("dbg_reg_access: type fields overlap enable bits");
   end

   dbg_sel_t                     wsel;
   dbg_sel_t                     rsel;
   logic                         wr_fire;
   logic [NUM_SLOTS-1:0][DW-1:0] addr_q;
   logic [DW-1:0]                stat_q;
   logic [DW-1:0]                ctrl_q;
   logic [NUM_SLOTS-1:0]         rearm_nxt;
   logic [DW-1:0]                rd_val;

   dbg_idx_decode u_wdec (
      .idx      (wr_idx),
      .ext_mode (dbg_ext_en),
      .sel      (wsel)
   );

   dbg_idx_decode u_rdec (
      .idx      (rd_idx),
      .ext_mode (dbg_ext_en),
      .sel      (rsel)
   );

   assign wr_fire   = wr_en && (wsel.tgt != TGT_BAD);
   assign acc_fault = (wr_en && wsel.tgt == TGT_BAD) || (rd_en && rsel.tgt == TGT_BAD);

   dbg_regfile #(
      .DW        (DW),
      .STAT_ONES (STAT_ONES),
      .CTRL_ONES (CTRL_ONES)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (wr_fire),
      .sel     (wsel),
      .wr_data (wr_data),
      .addr_q  (addr_q),
      .stat_q  (stat_q),
      .ctrl_q  (ctrl_q)
   );

   dbg_rearm_calc #(
      .DW        (DW),
      .TYPE_LSB  (TYPE_LSB),
      .IO_CODE   (IO_CODE),
      .CTRL_ONES (CTRL_ONES)
   ) u_rearm (
      .fire      (wr_fire),
      .sel       (wsel),
      .ctrl_q    (ctrl_q),
      .wr_data   (wr_data),
      .rearm_nxt (rearm_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rearm <= '0;
      else        rearm <= rearm_nxt;
   end

   always_comb begin
      case (rsel.tgt)
         TGT_ADDR: rd_val = addr_q[rsel.slot];
         TGT_STAT: rd_val = stat_q;
         TGT_CTRL: rd_val = ctrl_q;
         default:  rd_val = '0;
      endcase
   end

   if (REG_READ) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rd_data <= '0;
         else if (rd_en) rd_data <= rd_val;
      end
   end else begin : g_rd_comb
      assign rd_data = rd_val;
   end

endmodule

// File: rtl/dbg_reg_access_chk.sv
`timescale 1ns/1ps
module dbg_reg_access_chk #(
   parameter int unsigned    DW        = 32,
   parameter logic [DW-1:0]  STAT_ONES = 32'hFFFF_0FF0,
   parameter logic [DW-1:0]  CTRL_ONES = 32'h0000_0400
)(
   input logic          clk,
   input logic          rst_n,
   input logic          dbg_ext_en,
   input logic          wr_en,
   input logic [2:0]    wr_idx,
   input logic [DW-1:0] wr_data,
   input logic          rd_en,
   input logic          acc_fault,
   input logic [3:0]    rearm,
   input logic [DW-1:0] stat_q,
   input logic [DW-1:0] ctrl_q
);

   localparam logic [DW-1:0] EN_MASK = {{(DW-8){1'b0}}, 8'hFF};

   // R6
   fault_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fault |-> (wr_en || rd_en));

   // R5
   alias_write_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && dbg_ext_en && (wr_idx == 3'd4 || wr_idx == 3'd5)) |-> acc_fault);

   // R5
   fault_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && acc_fault) |=> ($stable(stat_q) && $stable(ctrl_q) && rearm == 4'h0));

   // R10
   idle_no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (rearm == 4'h0));

   // R3
   stat_fixed_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q & STAT_ONES) == STAT_ONES);

   // R3
   ctrl_fixed_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & CTRL_ONES) == CTRL_ONES);

   // R9
   wide_ctrl_all_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == 3'd7 && ((ctrl_q ^ (wr_data | CTRL_ONES)) & ~EN_MASK) != '0)
      |=> (rearm == 4'hF));

endmodule

bind dbg_reg_access dbg_reg_access_chk #(
   .DW        (DW),
   .STAT_ONES (STAT_ONES),
   .CTRL_ONES (CTRL_ONES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dbg_ext_en (dbg_ext_en),
   .wr_en      (wr_en),
   .wr_idx     (wr_idx),
   .wr_data    (wr_data),
   .rd_en      (rd_en),
   .acc_fault  (acc_fault),
   .rearm      (rearm),
   .stat_q     (stat_q),
   .ctrl_q     (ctrl_q)
);

// File: tb/sim_dbg_reg_access.sv
`timescale 1ns/1ps
module sim_dbg_reg_access;

   localparam logic [31:0] S1 = 32'hFFFF_0FF0;
   localparam logic [31:0] C1 = 32'h0000_0400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_ext_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_idx = '0;
   logic [31:0] rd_data;
   logic        acc_fault;
   logic [3:0]  rearm;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   logic [31:0] m_addr [4];
   logic [31:0] m_stat;
   logic [31:0] m_ctrl;

   always #2.5 clk = ~clk;

   dbg_reg_access u0 (
      .clk(clk), .rst_n(rst_n), .dbg_ext_en(dbg_ext_en),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
      .acc_fault(acc_fault), .rearm(rearm)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic string tag(input int idx, input bit ext);
      if (idx < 4) return "R2";
      if (idx >= 6) return "R3";
      return ext ? "R5" : "R4";
   endfunction

   function automatic bit illegal(input int idx, input bit ext);
      return ext && (idx == 4 || idx == 5);
   endfunction

   function automatic logic [31:0] model_rd(input int idx, input bit ext);
      if (illegal(idx, ext)) return 32'h0;
      if (idx < 4) return m_addr[idx];
      if (idx == 4 || idx == 6) return m_stat;
      return m_ctrl;
   endfunction

   function automatic logic [3:0] ctrl_rearm(input logic [31:0] o, input logic [31:0] d);
      logic [31:0] n;
      logic [3:0]  r;
      n = d | C1;
      r = 4'h0;
      if (((o ^ n) >> 8) != 0) return 4'hF;
      for (int i = 0; i < 4; i++)
         r[i] = (((o >> (2*i)) & 3) != 0) != (((n >> (2*i)) & 3) != 0);
      return r;
   endfunction

   function automatic logic [3:0] addr_rearm(input logic [31:0] c, input int slot);
      logic en;
      logic [1:0] ty;
      en = ((c >> (2*slot)) & 3) != 0;
      ty = 2'((c >> (16 + 4*slot)) & 3);
      return (en && ty != 2'b10) ? 4'(1 << slot) : 4'h0;
   endfunction

   task automatic do_rd(input int idx, input bit ext);
      @(negedge clk);
      wr_en = 1'b0;
      dbg_ext_en = ext;
      rd_en = 1'b1;
      rd_idx = 3'(idx);
      #1;
      chk(tag(idx, ext), rd_data, model_rd(idx, ext));
      chk(illegal(idx, ext) ? "R5" : "R6", {31'b0, acc_fault}, {31'b0, illegal(idx, ext)});
      rd_en = 1'b0;
   endtask

   // Write, check the fault pulse, then check the re-arm pulse one cycle later.
   task automatic do_wr(input int idx, input logic [31:0] d, input bit ext, input string rq);
      logic [3:0] exp_r;
      @(negedge clk);
      rd_en = 1'b0;
      dbg_ext_en = ext;
      wr_en = 1'b1;
      wr_idx = 3'(idx);
      wr_data = d;
      #1;
      chk(illegal(idx, ext) ? "R5" : "R6", {31'b0, acc_fault}, {31'b0, illegal(idx, ext)});
      exp_r = 4'h0;
      if (!illegal(idx, ext)) begin
         if (idx < 4) begin
            exp_r = addr_rearm(m_ctrl, idx);
            m_addr[idx] = d;
         end else if (idx == 4 || idx == 6) begin
            m_stat = d | S1;
         end else begin
            exp_r = ctrl_rearm(m_ctrl, d);
            m_ctrl = d | C1;
         end
      end
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      chk(rq, {28'b0, rearm}, {28'b0, exp_r});
   endtask

   initial begin
      for (int i = 0; i < 4; i++) m_addr[i] = 32'h0;
      m_stat = S1;
      m_ctrl = C1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", {28'b0, rearm}, 32'h0);
      chk("R1", {31'b0, acc_fault}, 32'h0);
      for (int i = 0; i < 8; i++) begin
         do_rd(i, 1'b0);
         chk("R1", rd_data, (i < 4) ? 32'h0 : ((i == 4 || i == 6) ? S1 : C1));
      end

      // Sweep 1: every index, both modes, write then read back everything
      for (int e = 0; e < 2; e++) begin
         for (int i = 0; i < 8; i++) begin
            do_wr(i, 32'h3C00_0000 ^ (32'(i) * 32'h0101_0101) ^ (32'(e) << 20),
                  bit'(e), (i == 6 || i == 4) ? "R10" : ((i < 4) ? "R7" : "R8"));
            for (int j = 0; j < 8; j++) begin
               do_rd(j, 1'b0);
               do_rd(j, 1'b1);
            end
         end
      end

      // Sweep 2: whole enable byte, upper bits untouched (narrow path)
      for (int n = 0; n < 256; n++)
         do_wr(7, (m_ctrl & 32'hFFFF_FF00) | 32'(n), 1'b0, "R8");

      // Single-bit flips above the enable byte; bit 10 flip is forced back
      for (int k = 8; k < 32; k++)
         do_wr(7, m_ctrl ^ (32'h1 << k), 1'b0, (k == 10) ? "R8" : "R9");

      // Sweep 3: slot types and enables, then an address write per slot
      for (int t = 0; t < 256; t++) begin
         logic [31:0] c;
         logic [7:0]  en;
         c = 32'h0;
         en = 8'(t) ^ 8'h5A;
         for (int s = 0; s < 4; s++)
            c[16 + 4*s +: 2] = 2'((t >> (2*s)) & 3);
         c[7:0] = en;
         do_wr(5, c, 1'b0, "R9");
         for (int s = 0; s < 4; s++)
            do_wr(s, 32'(t) * 32'h0001_0003 + 32'(s), 1'b0, "R7");
         do_rd(t % 4, 1'b0);
      end

      // Status writes never re-arm; an idle cycle has rearm at 0
      do_wr(6, 32'h0000_1234, 1'b0, "R10");
      do_rd(6, 1'b0);
      chk("R3", rd_data, 32'h0000_1234 | S1);
      @(negedge clk);
      #1;
      chk("R10", {28'b0, rearm}, 32'h0);
      // Faulting alias write in extension mode leaves state unchanged
      do_wr(5, 32'hFFFF_FFFF, 1'b1, "R5");
      do_rd(7, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nerr++;
         nchk++;
         $display("FAIL watchdog act=running exp=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule